// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Execution Unit

This block is the multiply-accumulate lane of a combined RISC/DSP execution pipeline. Each issued operation carries two 32-bit register operands, a two-bit operation code, a few option bits and a small shift amount taken from a mode register. The unit multiplies the operands as signed values. It then loads the result into a single 48-bit accumulator, adds it to the accumulator, or subtracts it from the accumulator. A separate read operation returns a scaled, optionally rounded and optionally clamped 32-bit or 16-bit copy of the accumulator for write-back.

Two multiply formats exist. Scalar mode multiplies the low 24 bits of each operand. Dual-halfword mode multiplies the two packed 16-bit lanes pairwise and sums the two products. The mode-register shift scales the product upward before it enters the accumulator, and it scales the accumulator downward on read-out. No extra shift instruction is needed. The work is spread over three execute stages: operand capture, multiply with scaling, and accumulate with read-out. A clamped read raises a sticky overflow flag, which software clears.

Top module: `dsp_mac_unit`

## Requirements
- R1: After a synchronous active-low reset, `acc_out` is 0, `wb_valid` is 0, `wb_data` is 0 and `ovf_sticky` is 0.
- R2: An operation presented with `in_valid` high at rising edge k takes effect at edge k+2, which updates `acc_out`, `wb_valid` and `wb_data`. One operation can be issued on every cycle.
- R3: Code 0 (load) replaces the accumulator with the scaled product.
- R4: Code 1 adds the scaled product to the accumulator. Code 2 subtracts the scaled product from the accumulator. Both arithmetic operations wrap modulo 2^48.
- R5: With `in_simd` low, the product is the signed value of `src_a[23:0]` times the signed value of `src_b[23:0]`. Bits 31:24 of both operands are ignored.
- R6: With `in_simd` high, the product is src_a[15:0]·src_b[15:0] plus src_a[31:16]·src_b[31:16], with every halfword signed.
- R7: For codes 0 to 2, the product is shifted left by `in_shamt` (0 to 7) before it is combined, and the shifted value wraps to 48 bits.
- R8: Code 3 (read) leaves the accumulator unchanged. It pulses `wb_valid` for one cycle and loads `wb_data` from the accumulator arithmetically shifted right by `in_shamt`. `wb_data` holds its value until the next read.
- R9: On a read with `in_rnd` high and `in_shamt` greater than 0, the value 2^(shamt-1) is added before the shift, which gives round-half-up. With shamt 0 there is no rounding.
- R10: On a read, `in_half` selects a 16-bit result (sign-extended to 32 bits) or a 32-bit result. With `in_sat` high, an out-of-range value clamps to 0x7FFFFFFF or 0x80000000, or in 16-bit mode to 0x00007FFF or 0xFFFF8000. With `in_sat` low, the low bits are kept.
- R11: A clamping read sets `ovf_sticky`, and the flag stays set until `clr_ovf` is sampled high. If a clamp happens in the same cycle as a clear, the set wins.
- R12: A cycle with `in_valid` low changes neither the accumulator nor the write-back outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | 0 load, 1 add, 2 subtract, 3 read |
| in_simd | input | 1 | Dual 16-bit lane multiply |
| in_half | input | 1 | Read result width: 1 = 16-bit, 0 = 32-bit |
| in_rnd | input | 1 | Round on read |
| in_sat | input | 1 | Clamp on read |
| in_shamt | input | 3 | Mode-register scale amount |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| clr_ovf | input | 1 | Clear sticky overflow |
| acc_out | output | 48 | Accumulator |
| wb_valid | output | 1 | Read result strobe |
| wb_data | output | 32 | Read result |
| ovf_sticky | output | 1 | Sticky saturation flag |

## Verification
The assertions rely on a few properties of the inputs. Reset is held for at least one clock edge before any operation is issued. The operation code and option bits are meaningful only while `in_valid` is high. `clr_ovf` is an ordinary level that is sampled on each edge. The stimulus keeps to these conditions. It holds reset over several edges, drives every input just after a falling edge, and includes cycles where `in_valid` is low but the data and code inputs carry deliberately random values. The dual-lane range check assumes the lane sum is observed with zero scale, and the directed extreme-lane cases cover exactly that situation.

// File: rtl/mac_pkg.sv
// Shared widths, operation codes and the per-stage control bundle for the
// multiply-accumulate unit. Assumes a 3-bit mode-register scale field.
package mac_pkg;
    localparam int SH_W = 3;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_READ = 2'd3
    } mac_op_e;

    typedef struct packed {
        logic            vld;
        mac_op_e         op;
        logic            simd;
        logic            half;
        logic            rnd;
        logic            sat;
        logic [SH_W-1:0] sh;
    } mac_ctl_t;
endpackage

// File: rtl/mac_mul_stage.sv
// Execute stages one and two: captures operands and control, forms the
// scalar or dual-lane signed product, applies the left scale and registers
// it. Assumes DATA_W splits into two equal lanes and ACC_W >= 2*MUL_W.
module mac_mul_stage
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 24,
    parameter int ACC_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mac_ctl_t          ctl_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output mac_ctl_t          ctl_o,
    output logic [ACC_W-1:0]  prod_o
);
    localparam int HW    = DATA_W / 2;
    localparam int LANES = DATA_W / HW;

    mac_ctl_t          e0_ctl;
    logic [DATA_W-1:0] e0_a, e0_b;
    logic signed [2*HW-1:0]    lane_p [LANES];
    logic signed [2*MUL_W-1:0] scal_p;
    logic signed [ACC_W-1:0]   lane_sum, raw_p, scaled_p;

    // Stage one control capture with reset so bubbles stay invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) e0_ctl <= '0;
        else        e0_ctl <= ctl_i;
    end

    // Stage one operand capture; data needs no reset.
    always_ff @(posedge clk) begin
        e0_a <= a_i;
        e0_b <= b_i;
    end

    // One signed halfword multiplier per packed lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_p[g] = $signed(e0_a[g*HW +: HW]) * $signed(e0_b[g*HW +: HW]);
    end

    // Sum the lane products at accumulator width.
    always_comb begin
        lane_sum = '0;
        for (int i = 0; i < LANES; i++) lane_sum = lane_sum + ACC_W'(lane_p[i]);
    end

    // Scalar product, format select and mode-register left scale.
    always_comb begin
        scal_p   = $signed(e0_a[MUL_W-1:0]) * $signed(e0_b[MUL_W-1:0]);
        raw_p    = e0_ctl.simd ? lane_sum : ACC_W'(scal_p);
        scaled_p = raw_p <<< e0_ctl.sh;
    end

    // Stage two register of control and scaled product.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_o <= '0;
        else        ctl_o <= e0_ctl;
    end

    // Product register; data needs no reset.
    always_ff @(posedge clk) begin
        prod_o <= scaled_p;
    end

    // Unscaled dual-lane sum always fits in DATA_W+1 signed bits.
    p_lane_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o.vld && ctl_o.simd && ctl_o.sh == '0)
        |-> prod_o[ACC_W-1:DATA_W] == {(ACC_W-DATA_W){prod_o[ACC_W-1]}});
endmodule

// File: rtl/mac_readout.sv
// Read-out path: arithmetic right scale with optional round-half-up,
// then 32-bit or 16-bit selection with optional clamping. Purely
// combinational; assumes DATA_W is even and ACC_W > DATA_W.
module mac_readout
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 48
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [SH_W-1:0]   sh_i,
    input  logic              rnd_i,
    input  logic              sat_i,
    input  logic              half_i,
    output logic [DATA_W-1:0] res_o,
    output logic              clamp_o
);
    localparam int HW = DATA_W / 2;
    localparam int EW = ACC_W + 1;

    logic signed [EW-1:0] ext_v, bias_v, shr_v;
    logic pos_w, neg_w, pos_h, neg_h, pos_o, neg_o;
    logic [DATA_W-1:0] keep_v, max_v, min_v;

    // Widen by one bit so the rounding bias cannot overflow, then scale.
    always_comb begin
        ext_v  = {acc_i[ACC_W-1], acc_i};
        bias_v = (rnd_i && sh_i != '0) ? (EW'(1) << (sh_i - 1'b1)) : '0;
        shr_v  = (ext_v + bias_v) >>> sh_i;
    end

    // Range detection against the full-word and halfword signed limits.
    always_comb begin
        pos_w = !shr_v[EW-1] &&  (|shr_v[EW-2:DATA_W-1]);
        neg_w =  shr_v[EW-1] && !(&shr_v[EW-2:DATA_W-1]);
        pos_h = !shr_v[EW-1] &&  (|shr_v[EW-2:HW-1]);
        neg_h =  shr_v[EW-1] && !(&shr_v[EW-2:HW-1]);
        pos_o = sat_i && (half_i ? pos_h : pos_w);
        neg_o = sat_i && (half_i ? neg_h : neg_w);
    end

    // Result select: kept low bits, or the clamp limit for the chosen width.
    always_comb begin
        keep_v = half_i ? {{HW{shr_v[HW-1]}}, shr_v[HW-1:0]} : shr_v[DATA_W-1:0];
        max_v  = half_i ? DATA_W'((1 << (HW-1)) - 1) : {1'b0, {(DATA_W-1){1'b1}}};
        min_v  = half_i ? ~max_v : {1'b1, {(DATA_W-1){1'b0}}};
        res_o  = pos_o ? max_v : (neg_o ? min_v : keep_v);
        clamp_o = pos_o || neg_o;
    end
endmodule

// File: rtl/dsp_mac_unit.sv
// Top of the multiply-accumulate unit: packs the issue bundle, runs the
// two multiply stages, then performs load/add/subtract or read-out in the
// third stage. Owns the accumulator, write-back register and sticky flag.
// Assumes the issuing pipeline tolerates a fixed two-edge result latency.
module dsp_mac_unit
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 24,
    parameter int ACC_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              in_simd,
    input  logic              in_half,
    input  logic              in_rnd,
    input  logic              in_sat,
    input  logic [SH_W-1:0]   in_shamt,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              clr_ovf,
    output logic [ACC_W-1:0]  acc_out,
    output logic              wb_valid,
    output logic [DATA_W-1:0] wb_data,
    output logic              ovf_sticky
);
    mac_ctl_t          issue_ctl, e1_ctl;
    logic [ACC_W-1:0]  e1_prod, acc_q;
    logic [DATA_W-1:0] rd_res;
    logic              rd_clamp, rd_now, sat_hit;

    // Bundle issue-side controls for the pipeline.
    always_comb begin
        issue_ctl.vld  = in_valid;
        issue_ctl.op   = mac_op_e'(in_op);
        issue_ctl.simd = in_simd;
        issue_ctl.half = in_half;
        issue_ctl.rnd  = in_rnd;
        issue_ctl.sat  = in_sat;
        issue_ctl.sh   = in_shamt;
    end

    mac_mul_stage #(.DATA_W(DATA_W), .MUL_W(MUL_W), .ACC_W(ACC_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .ctl_i(issue_ctl), .a_i(src_a), .b_i(src_b),
        .ctl_o(e1_ctl), .prod_o(e1_prod)
    );

    mac_readout #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_rd (
        .acc_i(acc_q), .sh_i(e1_ctl.sh), .rnd_i(e1_ctl.rnd), .sat_i(e1_ctl.sat),
        .half_i(e1_ctl.half), .res_o(rd_res), .clamp_o(rd_clamp)
    );

    assign rd_now  = e1_ctl.vld && (e1_ctl.op == OP_READ);
    assign sat_hit = rd_now && rd_clamp;

    // Stage three accumulate: load, add or subtract the scaled product.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else if (e1_ctl.vld) begin
            case (e1_ctl.op)
                OP_LOAD: acc_q <= e1_prod;
                OP_ADD:  acc_q <= acc_q + e1_prod;
                OP_SUB:  acc_q <= acc_q - e1_prod;
                default: acc_q <= acc_q;
            endcase
        end
    end

    // Stage three write-back register with one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= rd_now;
            if (rd_now) wb_data <= rd_res;
        end
    end

    // Sticky overflow: a clamp sets it and takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_sticky <= 1'b0;
        else if (sat_hit) ovf_sticky <= 1'b1;
        else if (clr_ovf) ovf_sticky <= 1'b0;
    end

    assign acc_out = acc_q;

    // Reads and bubbles leave the accumulator alone (R12 as well).
    p_acc_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!e1_ctl.vld || e1_ctl.op == OP_READ) |=> $stable(acc_out));

    // Write-back data only moves on a read.
    p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_now |=> $stable(wb_data));

    // The flag stays up without a clear.
    p_ovf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !clr_ovf) |=> ovf_sticky);

    // A clear with no concurrent clamp drops the flag.
    p_ovf_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !sat_hit) |=> !ovf_sticky);
endmodule

// File: tb/tb_dsp_mac_unit.sv
module tb_dsp_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = '0;
    logic        in_simd = 1'b0, in_half = 1'b0, in_rnd = 1'b0, in_sat = 1'b0;
    logic [2:0]  in_shamt = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        clr_ovf = 1'b0;
    logic [47:0] acc_out;
    logic        wb_valid;
    logic [31:0] wb_data;
    logic        ovf_sticky;

    always #4 clk = ~clk;

    dsp_mac_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_simd(in_simd), .in_half(in_half), .in_rnd(in_rnd), .in_sat(in_sat),
        .in_shamt(in_shamt), .src_a(src_a), .src_b(src_b), .clr_ovf(clr_ovf),
        .acc_out(acc_out), .wb_valid(wb_valid), .wb_data(wb_data),
        .ovf_sticky(ovf_sticky)
    );

    typedef struct {
        bit v; int op; bit simd, half, rnd, sat; int sh;
        logic [31:0] a, b;
    } op_t;

    op_t         pq[$];
    longint      m_acc;
    bit          m_wbv, m_ovf;
    logic [31:0] m_wbd;
    int          n_cmp = 0, n_bad = 0, cyc = 0;
    bit          started = 0, done = 0;
    string       cur_req = "R1";

    function automatic longint sx(longint v, int w);
        longint t = v & ((64'sd1 <<< w) - 1);
        if (((t >>> (w - 1)) & 1) != 0) t = t - (64'sd1 <<< w);
        return t;
    endfunction

    // Reference behaviour of one operation reaching the accumulate stage.
    function automatic void apply(op_t o, bit clr);
        bit set = 0;
        longint p, t, vv, hi, lo, r;
        m_wbv = 0;
        if (o.v) begin
            if (o.op == 3) begin
                t  = m_acc + ((o.rnd && o.sh > 0) ? (64'sd1 <<< (o.sh - 1)) : 0);
                vv = t >>> o.sh;
                hi = (64'sd1 <<< (o.half ? 15 : 31)) - 1;
                lo = -(64'sd1 <<< (o.half ? 15 : 31));
                if (o.sat && vv > hi)      begin r = hi; set = 1; end
                else if (o.sat && vv < lo) begin r = lo; set = 1; end
                else r = sx(vv, o.half ? 16 : 32);
                m_wbv = 1;
                m_wbd = r[31:0];
            end else begin
                if (o.simd)
                    p = sx(o.a[15:0], 16) * sx(o.b[15:0], 16)
                      + sx(o.a[31:16], 16) * sx(o.b[31:16], 16);
                else
                    p = sx(o.a[23:0], 24) * sx(o.b[23:0], 24);
                p = p <<< o.sh;
                case (o.op)
                    0:       m_acc = sx(p, 48);
                    1:       m_acc = sx(m_acc + p, 48);
                    default: m_acc = sx(m_acc - p, 48);
                endcase
            end
        end
        if (set) m_ovf = 1;
        else if (clr) m_ovf = 0;
    endfunction

    // Model pipeline: each edge accepts one slot and retires the one from two edges ago.
    always @(posedge clk) begin
        op_t cur, old;
        started = 1;
        cyc++;
        if (!rst_n) begin
            cur = '{default: 0};
            pq = {};
            pq.push_back(cur);
            pq.push_back(cur);
            m_acc = 0; m_wbv = 0; m_wbd = '0; m_ovf = 0;
        end else begin
            cur = '{in_valid, int'(in_op), in_simd, in_half, in_rnd, in_sat,
                    int'(in_shamt), src_a, src_b};
            pq.push_back(cur);
            old = pq.pop_front();
            apply(old, clr_ovf);
        end
    end

    // Compare every output with the model once per cycle.
    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (acc_out !== m_acc[47:0] || wb_valid !== m_wbv ||
                wb_data !== m_wbd || ovf_sticky !== m_ovf) begin
                n_bad++;
                $display("FAIL %s acc=%h/%h wbv=%0b/%0b wbd=%h/%h ovf=%0b/%0b (actual/expected)",
                         cur_req, acc_out, m_acc[47:0], wb_valid, m_wbv,
                         wb_data, m_wbd, ovf_sticky, m_ovf);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic issue(int op, bit simd, bit half, bit rnd, bit sat, int sh,
                         logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        in_valid = 1; in_op = op[1:0]; in_simd = simd; in_half = half;
        in_rnd = rnd; in_sat = sat; in_shamt = sh[2:0]; src_a = a; src_b = b;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue a read and check the write-back once it lands (two edges later).
    task automatic read_expect(string req, bit half, bit rnd, bit sat, int sh,
                               logic [31:0] exp);
        issue(3, 0, half, rnd, sat, sh, 32'h0, 32'h0);
        idle(1);
        @(negedge clk);
        @(negedge clk);
        check(req, {31'b0, wb_valid}, 32'd1);
        check(req, wb_data, exp);
    endtask

    initial begin
        logic [47:0] saved;
        // R1 reset values
        cur_req = "R1";
        repeat (5) @(negedge clk);
        check("R1", {15'b0, acc_out[47:31]}, 32'd0);
        check("R1", acc_out[31:0], 32'd0);
        check("R1", {30'b0, wb_valid, ovf_sticky}, 32'd0);
        check("R1", wb_data, 32'd0);
        rst_n = 1;

        cur_req = "R3";
        issue(0, 0, 0, 0, 0, 0, 32'd3, -32'sd7);
        read_expect("R3", 0, 0, 0, 0, -32'sd21);

        cur_req = "R5";
        issue(0, 0, 0, 0, 0, 0, 32'hAB000005, 32'h12000003);
        read_expect("R5", 0, 0, 0, 0, 32'd15);

        cur_req = "R4";
        issue(1, 0, 0, 0, 0, 0, 32'd10, 32'd10);
        issue(2, 0, 0, 0, 0, 0, 32'd200, 32'd1);
        read_expect("R4", 0, 0, 0, 0, -32'sd85);
        issue(0, 0, 0, 0, 0, 1, 32'h00800000, 32'h00800000);
        issue(1, 0, 0, 0, 0, 0, 32'd1, 32'd1);
        idle(3);
        check("R4", {16'b0, acc_out[47:32]}, 32'h8000);
        check("R4", acc_out[31:0], 32'd1);

        cur_req = "R6";
        issue(0, 1, 0, 0, 0, 0, 32'h80008000, 32'h80008000);
        read_expect("R6", 0, 0, 0, 0, 32'h80000000);
        cur_req = "R10";
        read_expect("R10", 0, 0, 1, 0, 32'h7FFFFFFF);
        check("R11", {31'b0, ovf_sticky}, 32'd1);
        cur_req = "R6";
        issue(1, 1, 0, 0, 0, 0, 32'h0003FFFE, 32'h00040005);
        read_expect("R6", 0, 0, 0, 0, 32'h80000002);

        cur_req = "R7";
        issue(0, 0, 0, 0, 0, 7, 32'd1, 32'd1);
        read_expect("R7", 0, 0, 0, 0, 32'd128);
        cur_req = "R8";
        read_expect("R8", 0, 0, 0, 4, 32'd8);
        check("R8", acc_out[31:0], 32'd128);
        idle(1);
        check("R8", {31'b0, wb_valid}, 32'd0);
        check("R8", wb_data, 32'd8);

        cur_req = "R9";
        issue(0, 0, 0, 0, 0, 0, 32'd5, 32'd1);
        read_expect("R9", 0, 1, 0, 1, 32'd3);
        issue(0, 0, 0, 0, 0, 0, -32'sd5, 32'd1);
        read_expect("R9", 0, 1, 0, 1, -32'sd2);
        read_expect("R9", 0, 0, 0, 1, -32'sd3);
        read_expect("R9", 0, 1, 0, 0, -32'sd5);

        cur_req = "R10";
        issue(0, 0, 0, 0, 0, 0, 32'h007FFFFF, 32'h007FFFFF);
        read_expect("R10", 1, 0, 1, 0, 32'h00007FFF);
        read_expect("R10", 1, 0, 0, 0, 32'h00000001);
        issue(0, 0, 0, 0, 0, 0, 32'h00800001, 32'h007FFFFF);
        read_expect("R10", 1, 0, 1, 0, 32'hFFFF8000);
        read_expect("R10", 0, 0, 1, 0, 32'h80000000);

        cur_req = "R11";
        @(negedge clk); clr_ovf = 1;
        @(negedge clk); clr_ovf = 0;
        check("R11", {31'b0, ovf_sticky}, 32'd0);
        clr_ovf = 1;
        read_expect("R11", 0, 0, 1, 0, 32'h80000000);
        check("R11", {31'b0, ovf_sticky}, 32'd1);
        clr_ovf = 0;

        cur_req = "R12";
        idle(3);
        saved = acc_out;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            in_valid = 0; in_op = 2'($urandom); src_a = $urandom; src_b = $urandom;
            in_shamt = 3'($urandom);
        end
        idle(2);
        check("R12", acc_out[31:0], saved[31:0]);
        check("R12", {31'b0, wb_valid}, 32'd0);

        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            in_valid = ($urandom % 5) != 0;
            in_op = 2'($urandom); in_simd = 1'($urandom); in_half = 1'($urandom);
            in_rnd = 1'($urandom); in_sat = 1'($urandom); in_shamt = 3'($urandom);
            src_a = $urandom; src_b = $urandom;
            clr_ovf = ($urandom % 7) == 0;
        end
        clr_ovf = 0;
        idle(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule